// File: doc/BRIEF.md
# Non-Overlapping Pulse Pattern Controller

This block drives an 8-bit pulse pattern from a next-pattern register, paced by a built-in trigger timer. An up-counter runs while a start bit is set and returns to zero after it matches a period compare value. A second, smaller compare value marks a guard point inside each period. Each pattern update is split into two steps. At the period boundary, only the bits that must go low are released. The bits that must go high are asserted later, at the guard point. Complementary phases therefore never conduct at the same time.

Non-overlap is selected separately for each 4-bit group of outputs. A group with non-overlap turned off takes its whole new value at the period boundary. Each output bit has an update enable. A bit whose enable is clear keeps its present level. The guard point also sets a sticky flag that software clears by writing a 1. The flag can raise an interrupt request, which tells software to load the next pattern in time.

All configuration goes through a single-cycle register write port. The register addresses are: 0 control, 1 guard compare, 2 period compare, 3 next pattern, 4 per-bit enable, 5 flag clear.

Top module: `nov_pattern_ctrl`

## Requirements
- R1: While running, the counter returns to 0 on the edge where it equals the period compare value (address 2). Successive guard-point flags are therefore period+1 cycles apart.
- R2: In a non-overlap group, rising bits appear guard+1 clock edges after the edge that applied the falling bits. The guard value is at address 1.
- R3: At the period boundary, each enabled bit of a non-overlap group becomes its current level AND its next-pattern bit.
- R4: At the guard point, each enabled bit of a non-overlap group takes its next-pattern bit.
- R5: With both groups in non-overlap mode, next patterns 0x95, 0x65, 0x59 and 0x56, followed by 0x95 again, produce the output changes 0x95, 0x05, 0x65, 0x41, 0x59, 0x50, 0x56, 0x14, 0x95 in that order.
- R6: A group with non-overlap off (control bit 2 for bits 3..0, bit 3 for bits 7..4) takes its full next value at the period boundary and does not change at the guard point.
- R7: An output bit whose enable bit (address 4, bit n for output n) is 0 never changes.
- R8: The guard point sets the flag. The interrupt output equals the flag while control bit 1 is 1, and is 0 while that bit is 0.
- R9: A write to address 5 with data bit 0 set clears the flag. A write with bit 0 clear leaves the flag unchanged.
- R10: With control bit 0 (run) at 0, the counter holds. No trigger occurs and the outputs do not change.
- R11: A guard value at or above the period value suppresses the guard point: there is no rise phase and no flag. A compare write applies from the next cycle.
- R12: A next-pattern write in the same cycle as a trigger is used by that trigger.
- R13: Reset clears the counter, the flag, the output pattern and all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| pat_o | output | 8 | Pattern outputs |
| flag_o | output | 1 | Guard-point flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A counter that drifts or clears at the wrong value shows up on the pattern pins within one period, as a shifted fall-to-rise spacing or flag spacing. A wrong group mode or a wrong enable mask produces an unexpected intermediate pattern at the next period boundary. Stale next-pattern data surfaces as an out-of-order value in the four-phase sequence one trigger later. Flag and interrupt mistakes are visible at the flag pins on the edge after the guard point.

// File: rtl/nov_pkg.sv
package nov_pkg;
  typedef enum logic [2:0] {
    ADDR_CTRL = 3'd0,
    ADDR_CMPA = 3'd1,
    ADDR_CMPB = 3'd2,
    ADDR_NEXT = 3'd3,
    ADDR_EN   = 3'd4,
    ADDR_FLAG = 3'd5
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IRQ_BIT = 1;
  localparam int CTRL_NOV_LSB = 2;
endpackage

// File: rtl/nov_regfile.sv
module nov_regfile
  import nov_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAT_W  = 8,
  parameter int N_GRP  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flag_set_i,
  output logic              run_o,
  output logic              irq_en_o,
  output logic [N_GRP-1:0]  nov_o,
  output logic [CNT_W-1:0]  cmpa_o,
  output logic [CNT_W-1:0]  cmpb_o,
  output logic [PAT_W-1:0]  next_eff_o,
  output logic [PAT_W-1:0]  en_o,
  output logic              flag_o
);
  localparam int CTRL_W = CTRL_NOV_LSB + N_GRP;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmpa_q, cmpb_q;
  logic [PAT_W-1:0]  next_q, en_q;
  logic              flag_q;
  logic              wr_ctrl, wr_cmpa, wr_cmpb, wr_next, wr_en, wr_flag;
  logic              unused_wr_bits;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_cmpa = wr_en_i && (wr_addr_i == ADDR_CMPA);
  assign wr_cmpb = wr_en_i && (wr_addr_i == ADDR_CMPB);
  assign wr_next = wr_en_i && (wr_addr_i == ADDR_NEXT);
  assign wr_en   = wr_en_i && (wr_addr_i == ADDR_EN);
  assign wr_flag = wr_en_i && (wr_addr_i == ADDR_FLAG);
  assign unused_wr_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      next_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data_i[CTRL_W-1:0];
      if (wr_cmpa) cmpa_q <= wr_data_i[CNT_W-1:0];
      if (wr_cmpb) cmpb_q <= wr_data_i[CNT_W-1:0];
      if (wr_next) next_q <= wr_data_i[PAT_W-1:0];
      if (wr_en)   en_q   <= wr_data_i[PAT_W-1:0];
    end
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flag_q <= 1'b0;
    else if (flag_set_i)              flag_q <= 1'b1;
    else if (wr_flag && wr_data_i[0]) flag_q <= 1'b0;
  end

  // same-cycle write is visible to a trigger in that cycle
  assign next_eff_o = wr_next ? wr_data_i[PAT_W-1:0] : next_q;

  assign run_o    = ctrl_q[CTRL_RUN_BIT];
  assign irq_en_o = ctrl_q[CTRL_IRQ_BIT];
  assign nov_o    = ctrl_q[CTRL_NOV_LSB +: N_GRP];
  assign cmpa_o   = cmpa_q;
  assign cmpb_o   = cmpb_q;
  assign en_o     = en_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/nov_trig_timer.sv
module nov_trig_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cmpb_i,
  output logic             ev_a_o,
  output logic             ev_b_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ev_b_o = run_i && (cnt_q == cmpb_i);
  // guard point only exists strictly inside the period
  assign ev_a_o = run_i && (cnt_q == cmpa_i) && (cmpa_i < cmpb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ev_b_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nov_out_stage.sv
module nov_out_stage #(
  parameter int PAT_W = 8,
  parameter int GRP_W = 4,
  parameter int N_GRP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_a_i,
  input  logic             ev_b_i,
  input  logic [N_GRP-1:0] nov_i,
  input  logic [PAT_W-1:0] en_i,
  input  logic [PAT_W-1:0] next_i,
  output logic [PAT_W-1:0] pat_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] grp_q, upd, nxt, nx, en;

    assign nx = next_i[g*GRP_W +: GRP_W];
    assign en = en_i[g*GRP_W +: GRP_W];

    always_comb begin
      upd = grp_q;
      if (ev_b_i)                upd = nov_i[g] ? (grp_q & nx) : nx;
      else if (ev_a_i && nov_i[g]) upd = nx;
      nxt = (upd & en) | (grp_q & ~en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) grp_q <= '0;
      else         grp_q <= nxt;
    end

    assign pat_o[g*GRP_W +: GRP_W] = grp_q;
  end
endmodule

// File: rtl/nov_pattern_ctrl.sv
module nov_pattern_ctrl #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAT_W  = 8,
  parameter int GRP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PAT_W-1:0]  pat_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int N_GRP = PAT_W / GRP_W;

  logic             run, irq_en, ev_a, ev_b;
  logic [N_GRP-1:0] nov;
  logic [CNT_W-1:0] cmpa, cmpb, cnt;
  logic [PAT_W-1:0] next_eff, en;

  nov_regfile #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PAT_W(PAT_W), .N_GRP(N_GRP)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .flag_set_i (ev_a),
    .run_o      (run),
    .irq_en_o   (irq_en),
    .nov_o      (nov),
    .cmpa_o     (cmpa),
    .cmpb_o     (cmpb),
    .next_eff_o (next_eff),
    .en_o       (en),
    .flag_o     (flag_o)
  );

  nov_trig_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .cmpa_i (cmpa),
    .cmpb_i (cmpb),
    .ev_a_o (ev_a),
    .ev_b_o (ev_b),
    .cnt_o  (cnt)
  );

  nov_out_stage #(.PAT_W(PAT_W), .GRP_W(GRP_W), .N_GRP(N_GRP)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_a_i (ev_a),
    .ev_b_i (ev_b),
    .nov_i  (nov),
    .en_i   (en),
    .next_i (next_eff),
    .pat_o  (pat_o)
  );

  assign irq_o = flag_o & irq_en;
endmodule

// File: rtl/nov_pattern_chk.sv
module nov_pattern_chk #(
  parameter int CNT_W = 16,
  parameter int PAT_W = 8,
  parameter int GRP_W = 4,
  parameter int N_GRP = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             ev_a_i,
  input logic             ev_b_i,
  input logic [N_GRP-1:0] nov_i,
  input logic [PAT_W-1:0] en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmpa_i,
  input logic [CNT_W-1:0] cmpb_i,
  input logic [PAT_W-1:0] pat_i,
  input logic             flag_i
);
  logic [PAT_W-1:0] nov_mask;
  for (genvar g = 0; g < N_GRP; g++) begin : g_mask
    assign nov_mask[g*GRP_W +: GRP_W] = {GRP_W{nov_i[g]}};
  end

  // R1
  period_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_b_i |=> (cnt_i == '0));

  // R3
  fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_b_i |=> ((pat_i & ~$past(pat_i) & $past(nov_mask)) == '0));

  // R6
  plain_group_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_a_i |=> (((pat_i ^ $past(pat_i)) & ~$past(nov_mask)) == '0));

  // R7
  masked_bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pat_i ^ $past(pat_i)) & ~$past(en_i)) == '0));

  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_a_i |=> flag_i);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(cnt_i) && $stable(pat_i)));

  // R11
  no_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpa_i >= cmpb_i) |-> !ev_a_i);
endmodule

bind nov_pattern_ctrl nov_pattern_chk #(
  .CNT_W(CNT_W), .PAT_W(PAT_W), .GRP_W(GRP_W), .N_GRP(N_GRP)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run),
  .ev_a_i (ev_a),
  .ev_b_i (ev_b),
  .nov_i  (nov),
  .en_i   (en),
  .cnt_i  (cnt),
  .cmpa_i (cmpa),
  .cmpb_i (cmpb),
  .pat_i  (pat_o),
  .flag_i (flag_o)
);

// File: tb/test_nov_pattern_ctrl.sv
module test_nov_pattern_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [7:0]  pat_o;
  logic        flag_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nov_pattern_ctrl i_nov_pattern_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pat_o(pat_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    wr_en_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wait_change(input logic [7:0] from, output int n);
    n = 0;
    while (pat_o == from && n < 200) begin @(negedge clk_i); n++; end
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] en, input logic [7:0] nx, input logic [3:0] ctrl);
    do_reset();
    wr(3'd1, a); wr(3'd2, b); wr(3'd4, {8'h0, en}); wr(3'd3, {8'h0, nx});
    wr(3'd0, {12'h0, ctrl});
  endtask

  task automatic t_reset();
    do_reset();
    check(pat_o == 8'h00, "R13 pattern", pat_o, 0);
    check(flag_o == 1'b0 && irq_o == 1'b0, "R13 flag/irq", {flag_o, irq_o}, 0);
  endtask

  task automatic t_sequence();
    logic [7:0] exp_seq [9] = '{8'h95, 8'h05, 8'h65, 8'h41, 8'h59, 8'h50, 8'h56, 8'h14, 8'h95};
    logic [7:0] loads [4] = '{8'h65, 8'h59, 8'h56, 8'h95};
    logic [7:0] prev = 8'h00;
    int k = 0;
    int j = 0;
    setup(16'd3, 16'd9, 8'hFF, 8'h95, 4'hF);
    for (int c = 0; c < 400 && k < 9; c++) begin
      @(negedge clk_i);
      if (pat_o != prev) begin
        check(pat_o == exp_seq[k], "R5 sequence step", pat_o, exp_seq[k]);
        prev = pat_o;
        k++;
      end
      if (flag_o) begin
        check(irq_o == 1'b1, "R8 irq with enable", irq_o, 1);
        if (j < 4) begin wr(3'd3, {8'h0, loads[j]}); j++; end
        wr(3'd5, 16'h1);
      end
    end
    check(k == 9, "R5 change count", k, 9);
  endtask

  task automatic t_timing();
    int n;
    setup(16'd2, 16'd7, 8'hFF, 8'h0F, 4'hD);
    wait_change(8'h00, n);
    check(pat_o == 8'h0F, "R4 rise applies next", pat_o, 8'h0F);
    wr(3'd3, 16'h00F0);
    wait_change(8'h0F, n);
    check(pat_o == 8'h00, "R3 fall phase only", pat_o, 8'h00);
    wait_change(8'h00, n);
    check(pat_o == 8'hF0 && n == 3, "R2 rise delay guard+1", n, 3);
    check(flag_o == 1'b1 && irq_o == 1'b0, "R8 irq masked", {flag_o, irq_o}, 2);
    wr(3'd5, 16'h1);
    n = 1;
    while (!flag_o && n < 100) begin @(negedge clk_i); n++; end
    check(n == 8, "R1 period spacing", n, 8);
  endtask

  task automatic t_group();
    int n;
    setup(16'd2, 16'd7, 8'hFF, 8'h11, 4'h9);
    wait_change(8'h00, n);
    check(pat_o == 8'h10, "R6 plain group waits at guard", pat_o, 8'h10);
    wait_change(8'h10, n);
    check(pat_o == 8'h11 && n == 5, "R6 plain group at boundary", {pat_o, n[7:0]}, 16'h1105);
  endtask

  task automatic t_mask();
    int n;
    setup(16'd2, 16'd7, 8'h0F, 8'hFF, 4'hD);
    wait_change(8'h00, n);
    repeat (20) @(negedge clk_i);
    check(pat_o == 8'h0F, "R7 disabled high bits", pat_o, 8'h0F);
    wr(3'd4, 16'h00F0);
    wr(3'd3, 16'h0000);
    repeat (20) @(negedge clk_i);
    check(pat_o == 8'h0F, "R7 disabled low bits kept", pat_o, 8'h0F);
  endtask

  task automatic t_cmp();
    int n;
    setup(16'd7, 16'd7, 8'hFF, 8'hFF, 4'hD);
    repeat (30) @(negedge clk_i);
    check(pat_o == 8'h00 && !flag_o, "R11 guard equal period", {pat_o, 7'h0, flag_o}, 0);
    wr(3'd1, 16'h0020);
    repeat (30) @(negedge clk_i);
    check(pat_o == 8'h00 && !flag_o, "R11 guard above period", {pat_o, 7'h0, flag_o}, 0);
    wr(3'd1, 16'h0003);
    wait_change(8'h00, n);
    check(pat_o == 8'hFF && flag_o && n <= 10, "R11 guard restored", pat_o, 8'hFF);
  endtask

  task automatic t_stop();
    int n;
    setup(16'd1, 16'd4, 8'hFF, 8'hFF, 4'hC);
    repeat (30) @(negedge clk_i);
    check(pat_o == 8'h00 && !flag_o, "R10 idle no trigger", pat_o, 0);
    wr(3'd0, 16'h000D);
    wait_change(8'h00, n);
    check(pat_o == 8'hFF, "R10 runs after start", pat_o, 8'hFF);
    wr(3'd0, 16'h000C);
    wr(3'd3, 16'h0000);
    repeat (30) @(negedge clk_i);
    check(pat_o == 8'hFF, "R10 stopped holds", pat_o, 8'hFF);
  endtask

  task automatic t_flag();
    setup(16'd2, 16'd7, 8'hFF, 8'h00, 4'hF);
    while (!flag_o) @(negedge clk_i);
    check(irq_o == 1'b1, "R8 irq follows flag", irq_o, 1);
    wr(3'd0, 16'h000C);
    check(flag_o && !irq_o, "R8 irq off when disabled", {flag_o, irq_o}, 2);
    wr(3'd0, 16'h000E);
    check(irq_o == 1'b1, "R8 irq re-enabled", irq_o, 1);
    wr(3'd5, 16'h0000);
    check(flag_o == 1'b1, "R9 write zero keeps flag", flag_o, 1);
    wr(3'd5, 16'h0001);
    check(!flag_o && !irq_o, "R9 write one clears", {flag_o, irq_o}, 0);
  endtask

  task automatic t_same_cycle();
    setup(16'd2, 16'd7, 8'hFF, 8'hFF, 4'hD);
    while (!flag_o) @(negedge clk_i);
    check(pat_o == 8'hFF, "R12 pre-state", pat_o, 8'hFF);
    repeat (4) @(negedge clk_i);
    wr(3'd3, 16'h0000);
    check(pat_o == 8'h00, "R12 same-cycle next used", pat_o, 8'h00);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_sequence();
    t_timing();
    t_group();
    t_mask();
    t_cmp();
    t_stop();
    t_flag();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule